// File: doc/BRIEF.md
# Serial Port with Receive Queue

This block is a full-duplex asynchronous serial port built around one 8-bit control and status byte. It sends and receives characters made of a low start bit and eight data bits, least significant bit first. An optional ninth bit can follow the data, and then come high stop bits. The ninth bit carries either a software-chosen level or a generated parity bit. The line timing comes from an external enable pulse that runs at the oversampling rate, so baud-rate division lives outside the block.

Received characters go into a short queue. Each queue entry holds the data byte together with its ninth bit and whether its parity check failed. This way the status fields always describe the oldest entry, which is the one software reads next. The receiver samples each bit several times and takes a majority vote near the middle of the bit. It rejects start pulses that are too short to be real. Interrupt-style flags for transmit and receive stay set until software writes zero to them. Software also sees sticky error flags for a lost character and for a parity mismatch.

Top module: `uartq`

## Requirements
- R1: After reset the control byte reads 0x20, `txd` is high, `tx_busy` is low and `rx_avail` is low.
- R2: Control bit 5 always reads 1 and ignores writes. Bit 4 (receive enable), bit 3 (transmit extra bit) and bit 2 (receive extra bit, only while the queue is empty) read back the value last written.
- R3: Bits 7 (overrun), 6 (parity error), 1 (transmit done) and 0 (receive done) are set only by hardware. A write of 0 clears them and a write of 1 leaves them unchanged.
- R4: A transmit write while idle sends a low start bit, the eight data bits LSB first, any ninth bit, and then STOP_BITS high stop bits, each bit lasting OVS ticks. A transmit write while `tx_busy` is high is ignored, and `txd` is high whenever `tx_busy` is low.
- R5: The ninth bit is sent when `cfg_nine` or `cfg_par_en` is 1. With parity on it is the parity bit: the XOR of the data for even parity (`cfg_par_odd`=0) or its inverse for odd parity. Otherwise it is control bit 3.
- R6: The transmit-done flag (bit 1) rises at the start of the first stop bit, one clock after `txd` goes high for it. It is not yet set during the last data or ninth bit.
- R7: A valid received character appears at `rx_data` with `rx_avail` high. The receive-done flag (bit 0) is set when the first stop bit is sampled. Each bit is decided by a majority of the three samples at oversampling counts MID-1, MID and MID+1.
- R8: The queue holds FIFO_DEPTH characters in arrival order. A character that completes while the queue is full is discarded and sets the overrun flag, and the stored characters are unchanged.
- R9: While receive enable is 0 no character is accepted and the receive-done flag is not set. Characters already queued can still be read and popped.
- R10: With the ninth bit in use, control bit 2 shows the ninth bit of the oldest queued character. With neither extra-bit mode nor parity on, it shows the level of that character's first stop bit.
- R11: With parity on, the parity-error flag is set while the oldest queued character's ninth bit differs from the parity of its data byte. It sets again after a clear for as long as that character stays at the head.
- R12: A start pulse that reads high at its middle samples is rejected: nothing is queued and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, OVS pulses per bit time |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read value |
| cfg_nine | input | 1 | Extra ninth-bit mode |
| cfg_par_en | input | 1 | Parity mode (ninth bit is parity) |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Transmitter sending a character |
| rx_pop | input | 1 | Remove the oldest queued character |
| rx_data | output | 8 | Oldest queued data byte |
| rx_avail | output | 1 | Queue not empty |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The bench builds the block with FIFO_DEPTH=2, OVS=16, STOP_BITS=1 and MID=8, and drives `os_tick` high every clock, so one bit lasts sixteen clocks. The shallow queue means three back-to-back characters without a pop already reach the overrun path. The short bit time lets a few dozen random frames cover every mix of ninth-bit mode, parity type and correct or corrupted parity within a short run. A four-clock low pulse lands well short of the majority window, which exercises start rejection.

// File: rtl/uartq_pkg.sv
package uartq_pkg;

    // Control byte bit positions (software-visible layout)
    localparam int unsigned CB_OVR  = 7;
    localparam int unsigned CB_PERR = 6;
    localparam int unsigned CB_ONE  = 5;
    localparam int unsigned CB_REN  = 4;
    localparam int unsigned CB_TBX  = 3;
    localparam int unsigned CB_RBX  = 2;
    localparam int unsigned CB_TI   = 1;
    localparam int unsigned CB_RI   = 0;

    localparam logic [7:0] CTL_RESET = 8'h20;

    typedef struct packed {
        logic [7:0] data;
        logic       ninth;
        logic       pbad;
    } rx_entry_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_NINTH,
        PH_STOP
    } phase_t;

    // even: XOR of data, odd: inverted
    function automatic logic parity_of(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/uartq_tx.sv
module uartq_tx
    import uartq_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int STOP_BITS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       has9,
    input  logic       bit9,
    output logic       txd,
    output logic       busy,
    output logic       stop_begin
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [3:0]    idx;
    logic [7:0]    sh;
    logic          h9;
    logic          b9;

    assign busy = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            idx        <= '0;
            sh         <= '0;
            h9         <= 1'b0;
            b9         <= 1'b0;
            txd        <= 1'b1;
            stop_begin <= 1'b0;
        end else begin
            stop_begin <= 1'b0;
            if (phase == PH_IDLE) begin
                if (load) begin
                    phase <= PH_START;
                    sh    <= load_data;
                    h9    <= has9;
                    b9    <= bit9;
                    txd   <= 1'b0;
                    cnt   <= '0;
                end
            end else if (os_tick) begin
                if (cnt == CW'(OVS - 1)) begin
                    cnt <= '0;
                    unique case (phase)
                        PH_START: begin
                            phase <= PH_DATA;
                            idx   <= '0;
                            txd   <= sh[0];
                        end
                        PH_DATA: begin
                            if (idx == 4'd7) begin
                                if (h9) begin
                                    phase <= PH_NINTH;
                                    txd   <= b9;
                                end else begin
                                    phase      <= PH_STOP;
                                    idx        <= '0;
                                    txd        <= 1'b1;
                                    stop_begin <= 1'b1;
                                end
                            end else begin
                                idx <= idx + 4'd1;
                                sh  <= sh >> 1;
                                txd <= sh[1];
                            end
                        end
                        PH_NINTH: begin
                            phase      <= PH_STOP;
                            idx        <= '0;
                            txd        <= 1'b1;
                            stop_begin <= 1'b1;
                        end
                        PH_STOP: begin
                            if (idx == 4'(STOP_BITS - 1)) phase <= PH_IDLE;
                            else                          idx   <= idx + 4'd1;
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/uartq_rx.sv
module uartq_rx
    import uartq_pkg::*;
#(
    parameter int OVS = 16,
    parameter int MID = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      os_tick,
    input  logic      enable,
    input  logic      nine_mode,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      rxd,
    output logic      done,
    output rx_entry_t entry
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;

    logic [1:0]    sy;
    logic          rxs;
    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic [7:0]    sh;
    logic [1:0]    votes;
    logic          h9, pe, po, n9;
    logic          bitval;
    logic          stop_ninth;

    assign rxs        = sy[1];
    assign bitval     = vote3({votes, rxs});
    assign stop_ninth = h9 ? n9 : bitval;

    always_ff @(posedge clk) begin
        if (rst) sy <= 2'b11;
        else     sy <= {sy[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            votes <= '0;
            h9    <= 1'b0;
            pe    <= 1'b0;
            po    <= 1'b0;
            n9    <= 1'b0;
            done  <= 1'b0;
            entry <= '0;
        end else begin
            done <= 1'b0;
            if (os_tick) begin
                if (phase == PH_IDLE) begin
                    if (enable && !rxs) begin
                        phase <= PH_START;
                        cnt   <= '0;
                        h9    <= nine_mode | par_en;
                        pe    <= par_en;
                        po    <= par_odd;
                    end
                end else begin
                    if (cnt == CW'(MID - 1) || cnt == CW'(MID))
                        votes <= {votes[0], rxs};
                    if (cnt == CW'(MID + 1)) begin
                        unique case (phase)
                            PH_START: if (bitval) phase <= PH_IDLE;
                            PH_DATA:  sh <= {bitval, sh[7:1]};
                            PH_NINTH: n9 <= bitval;
                            PH_STOP: begin
                                done        <= 1'b1;
                                entry.data  <= sh;
                                entry.ninth <= stop_ninth;
                                entry.pbad  <= pe & (stop_ninth != parity_of(sh, po));
                                phase       <= PH_IDLE;
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                    if (cnt == CW'(OVS - 1)) begin
                        cnt <= '0;
                        unique case (phase)
                            PH_START: begin
                                phase <= PH_DATA;
                                idx   <= '0;
                            end
                            PH_DATA: begin
                                if (idx == 3'd7) phase <= h9 ? PH_NINTH : PH_STOP;
                                else             idx   <= idx + 3'd1;
                            end
                            PH_NINTH: phase <= PH_STOP;
                            default:  phase <= PH_IDLE;
                        endcase
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uartq_fifo.sv
module uartq_fifo
    import uartq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  rx_entry_t       wentry,
    input  logic            pop,
    output rx_entry_t       head,
    output logic            empty,
    output logic            full,
    output logic [CNTW-1:0] count
);
    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNTW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wentry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            if (do_push && !do_pop)      count <= count + CNTW'(1);
            else if (do_pop && !do_push) count <= count - CNTW'(1);
        end
    end
endmodule

// File: rtl/uartq.sv
module uartq
    import uartq_pkg::*;
#(
    parameter int FIFO_DEPTH = 2,
    parameter int OVS        = 16,
    parameter int STOP_BITS  = 1,
    parameter int MID        = OVS / 2,
    localparam int CNTW      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       cfg_nine,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       tx_we,
    input  logic [7:0] tx_data,
    output logic       tx_busy,
    input  logic       rx_pop,
    output logic [7:0] rx_data,
    output logic       rx_avail,
    input  logic       rxd,
    output logic       txd
);
    logic f_ovr, f_perr, f_ren, f_tbx, f_rbx, f_ti, f_ri;

    logic            tx_load, tx_stop_begin;
    logic            rx_done, rx_take;
    rx_entry_t       rx_entry, q_head;
    logic            q_empty, q_full;
    logic [CNTW-1:0] q_count;

    assign tx_load = tx_we & ~tx_busy;
    assign rx_take = rx_done & f_ren;

    uartq_tx #(.OVS(OVS), .STOP_BITS(STOP_BITS)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .os_tick    (os_tick),
        .load       (tx_load),
        .load_data  (tx_data),
        .has9       (cfg_nine | cfg_par_en),
        .bit9       (cfg_par_en ? parity_of(tx_data, cfg_par_odd) : f_tbx),
        .txd        (txd),
        .busy       (tx_busy),
        .stop_begin (tx_stop_begin)
    );

    uartq_rx #(.OVS(OVS), .MID(MID)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .os_tick   (os_tick),
        .enable    (f_ren),
        .nine_mode (cfg_nine),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .rxd       (rxd),
        .done      (rx_done),
        .entry     (rx_entry)
    );

    uartq_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push   (rx_take & ~q_full),
        .wentry (rx_entry),
        .pop    (rx_pop),
        .head   (q_head),
        .empty  (q_empty),
        .full   (q_full),
        .count  (q_count)
    );

    assign rx_avail = ~q_empty;
    assign rx_data  = q_head.data;

    // sticky: hardware set wins, software may only clear
    function automatic logic sticky(input logic cur, input logic set,
                                    input logic we, input logic wbit);
        return set | (cur & (~we | wbit));
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            f_ovr  <= CTL_RESET[CB_OVR];
            f_perr <= CTL_RESET[CB_PERR];
            f_ren  <= CTL_RESET[CB_REN];
            f_tbx  <= CTL_RESET[CB_TBX];
            f_rbx  <= CTL_RESET[CB_RBX];
            f_ti   <= CTL_RESET[CB_TI];
            f_ri   <= CTL_RESET[CB_RI];
        end else begin
            f_ovr  <= sticky(f_ovr, rx_take & q_full, ctl_we, ctl_wdata[CB_OVR]);
            f_perr <= sticky(f_perr, ~q_empty & q_head.pbad, ctl_we, ctl_wdata[CB_PERR]);
            f_ti   <= sticky(f_ti, tx_stop_begin, ctl_we, ctl_wdata[CB_TI]);
            f_ri   <= sticky(f_ri, rx_take, ctl_we, ctl_wdata[CB_RI]);
            if (ctl_we) begin
                f_ren <= ctl_wdata[CB_REN];
                f_tbx <= ctl_wdata[CB_TBX];
            end
            if (!q_empty)    f_rbx <= q_head.ninth;
            else if (ctl_we) f_rbx <= ctl_wdata[CB_RBX];
        end
    end

    always_comb begin
        ctl_rdata          = '0;
        ctl_rdata[CB_OVR]  = f_ovr;
        ctl_rdata[CB_PERR] = f_perr;
        ctl_rdata[CB_ONE]  = 1'b1;
        ctl_rdata[CB_REN]  = f_ren;
        ctl_rdata[CB_TBX]  = f_tbx;
        ctl_rdata[CB_RBX]  = f_rbx;
        ctl_rdata[CB_TI]   = f_ti;
        ctl_rdata[CB_RI]   = f_ri;
    end
endmodule

// File: rtl/uartq_chk.sv
module uartq_chk #(
    parameter int DEPTH = 2,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            ctl_we,
    input logic [7:0]      ctl_rdata,
    input logic            txd,
    input logic            tx_busy,
    input logic            rx_avail,
    input logic [CNTW-1:0] q_count
);
    assert_bit5_one_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[5]);

    assert_ovr_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[7] && !ctl_we |=> ctl_rdata[7]);

    assert_ri_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[0] && !ctl_we |=> ctl_rdata[0]);

    assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    assert_ti_at_stop_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_rdata[1]) |-> txd && tx_busy);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNTW'(DEPTH));

    assert_ovr_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_rdata[7]) |-> $past(q_count) == CNTW'(DEPTH));

    assert_avail_matches_R8: assert property (@(posedge clk) disable iff (rst)
        rx_avail == (q_count != '0));

    assert_no_accept_R9: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[4] |=> q_count <= $past(q_count));
endmodule

bind uartq uartq_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_rdata (ctl_rdata),
    .txd       (txd),
    .tx_busy   (tx_busy),
    .rx_avail  (rx_avail),
    .q_count   (q_count)
);

// File: tb/uartq_tb.sv
module uartq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       tx_we = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_busy;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_avail;
    logic       rxd = 1'b1;
    logic       txd;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uartq #(.FIFO_DEPTH(2), .OVS(16), .STOP_BITS(1), .MID(8)) u_dut (.*);

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d, input logic odd);
        logic p = odd;
        for (int i = 0; i < 8; i++) p = p ^ d[i];
        return p;
    endfunction

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic pop_one();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic has9, input logic b9, input logic stp);
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (has9) drive_bit(b9);
        drive_bit(stp);
        rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic check_tx(input logic [7:0] d, input logic nine, input logic pe,
                            input logic odd, input logic tbx);
        logic [10:0] fr;
        int nb;
        cfg_nine = nine; cfg_par_en = pe; cfg_par_odd = odd;
        wr_ctl({4'b0001, tbx, 3'b000});
        fr = '1;
        fr[0] = 1'b0;
        fr[8:1] = d;
        if (nine || pe) begin
            fr[9] = pe ? exp_par(d, odd) : tbx;
            nb = 11;
        end else begin
            nb = 10;
        end
        @(negedge clk); tx_we = 1'b1; tx_data = d;
        @(negedge clk); tx_we = 1'b0;
        for (int i = 0; i < nb; i++) begin
            if (i > 0) begin
                @(negedge clk); tx_we = 1'b0;
                repeat (15) @(negedge clk);
            end else begin
                repeat (7) @(negedge clk);
            end
            chk(txd == fr[i], "R4/R5 tx bit", txd, fr[i]);
            if (i == nb - 2) chk(ctl_rdata[1] == 1'b0, "R6 ti before stop", ctl_rdata[1], 0);
            if (i == nb - 1) chk(ctl_rdata[1] == 1'b1, "R6 ti at stop", ctl_rdata[1], 1);
            if (i == 2) begin tx_we = 1'b1; tx_data = ~d; end  // R4 ignored while busy
        end
        repeat (16) @(negedge clk);
        chk(!tx_busy && txd, "R4 idle after frame", {tx_busy, txd}, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d, a, b;
        logic nine, pe, odd, b9, flip, has9, ebx, eperr;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(ctl_rdata == 8'h20, "R1 reset ctl", ctl_rdata, 8'h20);
        chk(txd && !tx_busy && !rx_avail, "R1 reset lines", {txd, tx_busy, rx_avail}, 3'b100);

        // R2 / R3: writes of 1 to flags do nothing, bit5 fixed
        wr_ctl(8'hFF);
        @(negedge clk);
        chk(ctl_rdata == 8'h3C, "R2/R3 write ones", ctl_rdata, 8'h3C);
        wr_ctl(8'h00);
        @(negedge clk);
        chk(ctl_rdata == 8'h20, "R2 write zeros", ctl_rdata, 8'h20);

        // R7 / R10 directed: plain frame, rbx = stop level
        cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0;
        wr_ctl(8'h10);
        send_rx(8'hA5, 0, 0, 1);
        chk(rx_avail && rx_data == 8'hA5, "R7 rx data", rx_data, 8'hA5);
        chk(ctl_rdata[0] == 1'b1, "R7 ri set", ctl_rdata[0], 1);
        chk(ctl_rdata[2] == 1'b1, "R10 rbx stop level", ctl_rdata[2], 1);
        pop_one();
        wr_ctl(8'h10);
        // R10 low stop bit
        send_rx(8'h3C, 0, 0, 0);
        chk(rx_data == 8'h3C && ctl_rdata[2] == 1'b0, "R10 rbx low stop", ctl_rdata[2], 0);
        pop_one();
        repeat (2) @(negedge clk);
        chk(!rx_avail, "R8 queue empty after pop", rx_avail, 0);
        wr_ctl(8'h10);

        // R8 overrun
        send_rx(8'h11, 0, 0, 1);
        send_rx(8'h22, 0, 0, 1);
        chk(ctl_rdata[7] == 1'b0, "R8 no ovr at depth", ctl_rdata[7], 0);
        send_rx(8'h33, 0, 0, 1);
        chk(ctl_rdata[7] == 1'b1, "R8 ovr set", ctl_rdata[7], 1);
        wr_ctl(8'h90);
        chk(ctl_rdata[7] == 1'b1, "R3 write one keeps ovr", ctl_rdata[7], 1);
        chk(rx_data == 8'h11, "R8 oldest first", rx_data, 8'h11);
        pop_one();
        chk(rx_data == 8'h22, "R8 second kept", rx_data, 8'h22);
        pop_one();
        chk(!rx_avail, "R8 dropped char absent", rx_avail, 0);
        wr_ctl(8'h10);
        chk(ctl_rdata[7] == 1'b0, "R3 ovr cleared by zero", ctl_rdata[7], 0);

        // R9 receive disabled
        wr_ctl(8'h00);
        send_rx(8'h5A, 0, 0, 1);
        chk(!rx_avail && !ctl_rdata[0], "R9 ignored when off", {rx_avail, ctl_rdata[0]}, 0);
        wr_ctl(8'h10);
        send_rx(8'h77, 0, 0, 1);
        wr_ctl(8'h00);
        send_rx(8'h88, 0, 0, 1);
        chk(rx_avail && rx_data == 8'h77, "R9 stored readable", rx_data, 8'h77);
        pop_one();
        chk(!rx_avail, "R9 second not queued", rx_avail, 0);

        // R12 glitch start
        wr_ctl(8'h10);
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        chk(!rx_avail && ctl_rdata[0] == 1'b0, "R12 glitch rejected", {rx_avail, ctl_rdata[0]}, 0);
        send_rx(8'hC3, 0, 0, 1);
        chk(rx_data == 8'hC3, "R12 valid after glitch", rx_data, 8'hC3);
        pop_one();
        wr_ctl(8'h10);

        // R11 parity error re-sets while bad head stays
        cfg_par_en = 1; cfg_par_odd = 0;
        send_rx(8'h01, 1, 1'b0, 1);
        chk(ctl_rdata[6] == 1'b1, "R11 perr set", ctl_rdata[6], 1);
        wr_ctl(8'h10);
        @(negedge clk);
        chk(ctl_rdata[6] == 1'b1, "R11 perr re-set", ctl_rdata[6], 1);
        pop_one();
        wr_ctl(8'h10);
        @(negedge clk);
        chk(ctl_rdata[6] == 1'b0, "R3 perr cleared", ctl_rdata[6], 0);

        // random receive frames: R7 R10 R11
        for (int k = 0; k < 24; k++) begin
            d = 8'($urandom);
            nine = 1'($urandom); pe = 1'($urandom); odd = 1'($urandom);
            flip = (($urandom % 4) == 0);
            cfg_nine = nine; cfg_par_en = pe; cfg_par_odd = odd;
            has9 = nine | pe;
            b9 = pe ? (exp_par(d, odd) ^ flip) : 1'($urandom);
            ebx = has9 ? b9 : 1'b1;
            eperr = pe && (b9 != exp_par(d, odd));
            send_rx(d, has9, b9, 1);
            chk(rx_avail && rx_data == d, "R7 rand data", rx_data, d);
            chk(ctl_rdata[2] == ebx, "R10 rand rbx", ctl_rdata[2], ebx);
            chk(ctl_rdata[6] == eperr, "R11 rand perr", ctl_rdata[6], eperr);
            chk(ctl_rdata[0] == 1'b1, "R7 rand ri", ctl_rdata[0], 1);
            pop_one();
            wr_ctl(8'h10);
        end

        // transmit: directed then random (R4 R5 R6)
        check_tx(8'h96, 0, 0, 0, 0);
        check_tx(8'h0F, 1, 0, 0, 1);
        check_tx(8'h0F, 1, 1, 1, 0);
        for (int k = 0; k < 10; k++) begin
            a = 8'($urandom);
            check_tx(a, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        b = 8'h00;
        check_tx(b, 0, 1, 0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule